// File: doc/BRIEF.md
# USB connect and speed detector

This block watches the synchronized two-wire USB line state, sampled on the 48 MHz logic clock. It reports whether a device is absent, attached at low speed or attached at full speed. A device announces itself by pulling one data line high, which leaves an idle level on the pair. The polarity of that idle level tells the speed.

An attach is accepted only once the idle level has held without a break for a qualifying interval. A detach is accepted only once SE0 has held for a qualifying interval. Shorter glitches in either direction are filtered out.

The detector has seven states: one disconnected state, and for each speed a connect-qualify state, a connected state and a disconnect-qualify state. A single shared debounce counter times both qualifying intervals. Both intervals default to 120 clocks, about 2.5 µs.

Top module: `usb_conn_detect`

## Requirements
- R1: While rst_ni is low, and after its release until the first qualified attach, conn_o is 00 (no device).
- R2: conn_o only takes the codes 00 (no device), 01 (low speed) and 10 (full speed). It never shows 11.
- R3: From the disconnected state, line_i = 10 ({D+,D-}, D+ high) sampled on CONN_CYC+1 consecutive rising edges makes conn_o read 10 after that last edge. It still reads 00 after CONN_CYC such edges.
- R4: From the disconnected state, line_i = 01 (D- high) sampled on CONN_CYC+1 consecutive rising edges makes conn_o read 01 after that last edge. It still reads 00 after CONN_CYC such edges.
- R5: While an attach is being qualified, any other line value returns the detector to the disconnected state. That sample is not counted toward a new attach, so a new idle value then needs CONN_CYC+2 consecutive samples in total.
- R6: While connected, line_i = 00 (SE0) sampled on DISC_CYC+1 consecutive edges makes conn_o read 00 after that last edge.
- R7: An SE0 run shorter than DISC_CYC+1 samples leaves the device connected. A later SE0 run is timed from its own start.
- R8: While connected, the line values 01, 10 and 11 other than SE0 leave conn_o unchanged, whatever the polarity of the idle level.
- R9: conn_o keeps the speed code while a detach is being qualified. It stays 00 while an attach is being qualified.
- R10: In the disconnected state, line values 00 and 11 keep conn_o at 00 for any duration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 48 MHz logic clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 2 | Synchronized line state {D+, D-} |
| conn_o | output | 2 | Attach status: 00 none, 01 low speed, 10 full speed |

## Verification
Every result lands on the rising edge that samples the last qualifying line value. Attach needs CONN_CYC+1 samples, or CONN_CYC+2 after an aborted qualification. Detach needs DISC_CYC+1 samples of SE0. A glitch back to the connected state takes effect on the first edge that sees a value other than SE0.

The bench drives line_i on falling edges and steps its own behavioural model once per driven value. It compares conn_o with the model on every falling edge, which falls after the edge that acted on the previous value. Directed checks sample 1 ns after a rising edge, one cycle before and one cycle at each threshold.

// File: rtl/usb_conn_pkg.sv
package usb_conn_pkg;
  typedef enum logic [1:0] {
    LINE_SE0   = 2'b00,
    LINE_DIFF0 = 2'b01,
    LINE_DIFF1 = 2'b10,
    LINE_SE1   = 2'b11
  } line_e;

  typedef enum logic [1:0] {
    LINK_OFF = 2'b00,
    LINK_LS  = 2'b01,
    LINK_FS  = 2'b10
  } link_e;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_FS_QUAL = 3'd1,
    ST_LS_QUAL = 3'd2,
    ST_LS_UP   = 3'd3,
    ST_FS_UP   = 3'd4,
    ST_LS_DROP = 3'd5,
    ST_FS_DROP = 3'd6
  } st_e;
endpackage

// File: rtl/usb_conn_timer.sv
module usb_conn_timer #(
  parameter int unsigned CONN_CYC = 120,
  parameter int unsigned DISC_CYC = 120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic conn_hit_o,
  output logic disc_hit_o
);
  localparam int unsigned MAX_CYC = (CONN_CYC > DISC_CYC) ? CONN_CYC : DISC_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(MAX_CYC);
  localparam logic [CNT_W-1:0] CONN_LAST = CNT_W'(CONN_CYC - 1);
  localparam logic [CNT_W-1:0] DISC_LAST = CNT_W'(DISC_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  // saturating so idle states never wrap into a false hit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign conn_hit_o = (cnt_q == CONN_LAST);
  assign disc_hit_o = (cnt_q == DISC_LAST);

  a_r5_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  a_r7_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_q != CNT_TOP) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/usb_conn_fsm.sv
module usb_conn_fsm
  import usb_conn_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] line_i,
  input  logic       conn_hit_i,
  input  logic       disc_hit_i,
  output logic       clr_o,
  output logic [1:0] conn_o
);
  st_e   st_q, st_d;
  line_e line;
  link_e link;

  assign line = line_e'(line_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF: begin
        if (line == LINE_DIFF1)      st_d = ST_FS_QUAL;
        else if (line == LINE_DIFF0) st_d = ST_LS_QUAL;
      end
      ST_FS_QUAL: begin
        if (line != LINE_DIFF1) st_d = ST_OFF;
        else if (conn_hit_i)    st_d = ST_FS_UP;
      end
      ST_LS_QUAL: begin
        if (line != LINE_DIFF0) st_d = ST_OFF;
        else if (conn_hit_i)    st_d = ST_LS_UP;
      end
      ST_FS_UP: if (line == LINE_SE0) st_d = ST_FS_DROP;
      ST_LS_UP: if (line == LINE_SE0) st_d = ST_LS_DROP;
      ST_FS_DROP: begin
        if (line != LINE_SE0) st_d = ST_FS_UP;
        else if (disc_hit_i)  st_d = ST_OFF;
      end
      ST_LS_DROP: begin
        if (line != LINE_SE0) st_d = ST_LS_UP;
        else if (disc_hit_i)  st_d = ST_OFF;
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  assign clr_o = (st_d != st_q);

  always_comb begin
    unique case (st_q)
      ST_LS_UP, ST_LS_DROP: link = LINK_LS;
      ST_FS_UP, ST_FS_DROP: link = LINK_FS;
      default:              link = LINK_OFF;
    endcase
  end
  assign conn_o = link;

  a_r3_fs_attach_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FS_QUAL && line == LINE_DIFF1 && !conn_hit_i) |=> st_q == ST_FS_QUAL);
  a_r4_ls_attach_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LS_QUAL && line == LINE_DIFF0 && !conn_hit_i) |=> st_q == ST_LS_QUAL);
  a_r5_abort_to_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_FS_QUAL && line != LINE_DIFF1) || (st_q == ST_LS_QUAL && line != LINE_DIFF0))
    |=> st_q == ST_OFF);
  a_r6_detach_needs_se0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q inside {ST_FS_DROP, ST_LS_DROP} && line == LINE_SE0 && disc_hit_i) |=> conn_o == 2'b00);
  a_r8_up_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q inside {ST_FS_UP, ST_LS_UP} && line != LINE_SE0) |=> $stable(conn_o));
  a_r10_off_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OFF && line inside {LINE_SE0, LINE_SE1}) |=> conn_o == 2'b00);
endmodule

// File: rtl/usb_conn_detect.sv
module usb_conn_detect #(
  parameter int unsigned CONN_CYC = 120,
  parameter int unsigned DISC_CYC = 120
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] line_i,
  output logic [1:0] conn_o
);
  logic clr, conn_hit, disc_hit;

  usb_conn_timer #(
    .CONN_CYC(CONN_CYC),
    .DISC_CYC(DISC_CYC)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .conn_hit_o(conn_hit),
    .disc_hit_o(disc_hit)
  );

  usb_conn_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (line_i),
    .conn_hit_i(conn_hit),
    .disc_hit_i(disc_hit),
    .clr_o     (clr),
    .conn_o    (conn_o)
  );

  a_r2_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conn_o != 2'b11);
  a_r9_speed_kept_in_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conn_o != 2'b00 && line_i == 2'b00) |=> (conn_o == $past(conn_o) || conn_o == 2'b00));
endmodule

// File: tb/usb_conn_detect_tb.sv
module usb_conn_detect_tb;
  localparam int N = 120;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] line = 2'b00;
  logic [1:0] conn;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  // behavioural reference: phase 0 off, 1 attach qualify, 2 up, 3 detach qualify
  int m_ph = 0, m_spd = 0, m_cnt = 0;

  always #2.5 clk = ~clk;

  usb_conn_detect #(.CONN_CYC(N), .DISC_CYC(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .conn_o(conn));

  function automatic int m_out();
    return (m_ph >= 2) ? m_spd : 0;
  endfunction

  task automatic m_step(input logic [1:0] v);
    case (m_ph)
      0: if (v == 2'b10 || v == 2'b01) begin m_ph = 1; m_spd = (v == 2'b10) ? 2 : 1; m_cnt = 0; end
      1: if (v != ((m_spd == 2) ? 2'b10 : 2'b01)) m_ph = 0;
         else if (m_cnt == N - 1) m_ph = 2;
         else m_cnt++;
      2: if (v == 2'b00) begin m_ph = 3; m_cnt = 0; end
      default: if (v != 2'b00) m_ph = 2;
         else if (m_cnt == N - 1) m_ph = 0;
         else m_cnt++;
    endcase
  endtask

  task automatic cmp(input int exp, input string t);
    n_chk++;
    if (conn !== 2'(exp)) begin
      n_fail++;
      $display("FAIL %s: conn_o=%b expected=%b at %0t", t, conn, 2'(exp), $time);
    end
  endtask

  task automatic hold(input logic [1:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp(m_out(), tag);
      line = v;
      m_step(v);
    end
  endtask

  task automatic check(input int exp, input string t);
    @(posedge clk); #1;
    cmp(exp, t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp(0, "R1");
    rst_n = 1'b1;
    check(0, "R1");

    tag = "R10"; hold(2'b00, 150); hold(2'b11, 150); check(0, "R10");

    tag = "R9"; hold(2'b10, N); check(0, "R3");
    hold(2'b10, 1); check(2, "R3");

    tag = "R8"; hold(2'b01, 60); hold(2'b11, 60); hold(2'b10, 10); check(2, "R8");

    tag = "R7"; hold(2'b00, N); check(2, "R9");
    hold(2'b10, 1); check(2, "R7");
    hold(2'b00, N); check(2, "R7");
    tag = "R6"; hold(2'b00, 1); check(0, "R6");

    tag = "R5"; hold(2'b01, N / 2); hold(2'b10, N / 2); hold(2'b01, N + 1); check(0, "R5");
    tag = "R4"; hold(2'b01, 1); check(1, "R4");
    tag = "R8"; hold(2'b10, 40); hold(2'b11, 40); check(1, "R8");

    tag = "R6"; hold(2'b00, N); check(1, "R9");
    hold(2'b00, 1); check(0, "R6");
    tag = "R2"; hold(2'b11, 20); hold(2'b10, 2 * N); hold(2'b00, 2 * N);
    check(0, "R2");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule